// File: doc/BRIEF.md
# Power-Management System-Control Interrupt Generator

This block holds the 16-bit power-management event status, event enable and control words, and turns them into a level-sensitive system-control interrupt. External event pulses set status bits. Software clears them by writing ones to the bit positions it wants cleared. The enable and control words are plain loadable registers behind simple write strobes.

The interrupt is a registered level. Only four event sources can raise it: the timer overflow, the global lock, the power button and the real-time-clock alarm. A configured interrupt-pin value of zero means no pin is wired, and the block then holds the interrupt low.

The block also drives a timer-arm flag. This flag tells the external timer logic that an overflow event is wanted, because the timer source is enabled and its status is still clear.

Top module: `pmSciGen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status, enable and control words read 0, and `sciOut` and `tmrArm` are 0.
- R2: A 1 on bit n of `evtIn` at a clock edge sets status bit n at that edge. The bit then stays set until it is cleared.
- R3: With `stsClrWe` high, each status bit whose `wrData` bit is 1 is cleared at the edge. Status bits whose `wrData` bit is 0 keep their value.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `enWe` loads `wrData` into the enable word, and `cntWe` loads `wrData` into the control word. A word whose strobe is low keeps its value.
- R6: One edge after any change to status, enable or pin value, `sciOut` equals 1 exactly when `intPin` is nonzero and status AND enable is nonzero in at least one of these bit positions: 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time-clock alarm).
- R7: Status and enable bits in positions other than 0, 5, 8 and 10 never raise `sciOut`.
- R8: While `intPin` is zero, `sciOut` stays 0 whatever the status and enable words hold.
- R9: One edge after the words change, `tmrArm` equals enable bit 0 AND NOT status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 16 | Event pulses, one per status bit |
| wrData | input | 16 | Write data shared by all write strobes |
| stsClrWe | input | 1 | Write-one-to-clear strobe for the status word |
| enWe | input | 1 | Load strobe for the enable word |
| cntWe | input | 1 | Load strobe for the control word |
| intPin | input | 8 | Configured interrupt-pin value; zero suppresses the interrupt |
| stsOut | output | 16 | Current status word |
| enOut | output | 16 | Current enable word |
| cntOut | output | 16 | Current control word |
| sciOut | output | 1 | Registered system-control interrupt level |
| tmrArm | output | 1 | Registered timer overflow arm flag |

## Verification
The bench sweeps every bit position against all combinations of status set, enable set and pin value zero or nonzero. This sweep exposes three kinds of fault: a wrong source mask, where a non-source bit raises the interrupt or a source bit stays silent; a missing pin gate, where the interrupt rises with the pin at zero; and an arm flag that ignores the timer status. Directed cases go after the following:
- a set and a clear landing on the same bit in one cycle, where a clear-priority design loses the event;
- a partial write-one-to-clear, where a design that loads instead of clears wipes out neighbouring bits;
- the one-cycle interrupt latency, where a combinational output rises an edge early.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int unsigned WORD_W = 16;

  typedef struct packed {
    logic [WORD_W-1:0] setMask;
    logic [WORD_W-1:0] clrMask;
    logic              enLoad;
    logic              cntLoad;
  } sciStrobe_t;
endpackage

// File: rtl/sci_datapath.sv
module sci_datapath
  import sci_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sciStrobe_t        strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] stsQ,
  output logic [WORD_W-1:0] enQ,
  output logic [WORD_W-1:0] cntQ
);
  logic [WORD_W-1:0] stsNext;

  // Set has priority over clear on the same bit.
  always_comb stsNext = (stsQ & ~strb.clrMask) | strb.setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ <= '0;
      enQ  <= '0;
      cntQ <= '0;
    end else begin
      stsQ <= stsNext;
      if (strb.enLoad)  enQ  <= wrData;
      if (strb.cntLoad) cntQ <= wrData;
    end
  end

  // R2 / R4: every pulsed bit is set next cycle, even under a clear
  a_r4_set_over_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask != '0) |=> ((stsQ & $past(strb.setMask)) == $past(strb.setMask)));

  // R3: cleared bits without a set are zero next cycle
  a_r3_clear_only_ones: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.clrMask & ~strb.setMask) != '0) |=>
      ((stsQ & $past(strb.clrMask & ~strb.setMask)) == '0));

  // R2: untouched bits hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask == '0 && strb.clrMask == '0) |=> $stable(stsQ));

  // R5: enable word holds without a load
  a_r5_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enLoad |=> $stable(enQ));
endmodule

// File: rtl/sci_control.sv
module sci_control
  import sci_pkg::*;
#(
  parameter int unsigned PIN_W   = 8,
  parameter int unsigned TMR_BIT = 0,
  parameter int unsigned GBL_BIT = 5,
  parameter int unsigned PWR_BIT = 8,
  parameter int unsigned RTC_BIT = 10
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] evtIn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              stsClrWe,
  input  logic              enWe,
  input  logic              cntWe,
  input  logic [PIN_W-1:0]  intPin,
  input  logic [WORD_W-1:0] stsQ,
  input  logic [WORD_W-1:0] enQ,
  output sciStrobe_t        strb,
  output logic              sciOut,
  output logic              tmrArm
);
  localparam logic [WORD_W-1:0] SRC_MASK =
    (WORD_W'(1) << TMR_BIT) | (WORD_W'(1) << GBL_BIT) |
    (WORD_W'(1) << PWR_BIT) | (WORD_W'(1) << RTC_BIT);

  logic [WORD_W-1:0] pendSrc;
  logic              pinWired;
  logic              sciNext;
  logic              armNext;

  always_comb begin
    strb.setMask = evtIn;
    strb.clrMask = stsClrWe ? wrData : '0;
    strb.enLoad  = enWe;
    strb.cntLoad = cntWe;
  end

  always_comb begin
    pendSrc  = stsQ & enQ & SRC_MASK;
    pinWired = (intPin != '0);
    sciNext  = pinWired && (pendSrc != '0);
    armNext  = enQ[TMR_BIT] && !stsQ[TMR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sciOut <= 1'b0;
      tmrArm <= 1'b0;
    end else begin
      sciOut <= sciNext;
      tmrArm <= armNext;
    end
  end

  // R8: an unwired pin keeps the interrupt low
  a_r8_pin_zero: assert property (@(posedge clk) disable iff (!rstN)
    (intPin == '0) |=> !sciOut);

  // R7: nothing pending among the four sources -> low
  a_r7_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((stsQ & enQ & SRC_MASK) == '0) |=> !sciOut);

  // R6: pending source with wired pin -> high next cycle
  a_r6_raise: assert property (@(posedge clk) disable iff (!rstN)
    (intPin != '0 && (stsQ & enQ & SRC_MASK) != '0) |=> sciOut);

  // R9: arm follows timer enable and clear timer status
  a_r9_arm: assert property (@(posedge clk) disable iff (!rstN)
    (enQ[TMR_BIT] && !stsQ[TMR_BIT]) |=> tmrArm);
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rstN)
    stsQ[TMR_BIT] |=> !tmrArm);
endmodule

// File: rtl/pmSciGen.sv
module pmSciGen
  import sci_pkg::*;
#(
  parameter int unsigned PIN_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] evtIn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              stsClrWe,
  input  logic              enWe,
  input  logic              cntWe,
  input  logic [PIN_W-1:0]  intPin,
  output logic [WORD_W-1:0] stsOut,
  output logic [WORD_W-1:0] enOut,
  output logic [WORD_W-1:0] cntOut,
  output logic              sciOut,
  output logic              tmrArm
);
  sciStrobe_t        strb;
  logic [WORD_W-1:0] stsQ;
  logic [WORD_W-1:0] enQ;
  logic [WORD_W-1:0] cntQ;

  sci_control #(.PIN_W(PIN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrData(wrData),
    .stsClrWe(stsClrWe), .enWe(enWe), .cntWe(cntWe), .intPin(intPin),
    .stsQ(stsQ), .enQ(enQ), .strb(strb), .sciOut(sciOut), .tmrArm(tmrArm)
  );

  sci_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .stsQ(stsQ), .enQ(enQ), .cntQ(cntQ)
  );

  assign stsOut = stsQ;
  assign enOut  = enQ;
  assign cntOut = cntQ;

  // R1: registers are zero in the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    (!rstN) |=> (stsQ == '0 && enQ == '0 && cntQ == '0 && !sciOut));
endmodule

// File: tb/sim_pmSciGen.sv
module sim_pmSciGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic [15:0] wrData = '0;
  logic        stsClrWe = 1'b0;
  logic        enWe = 1'b0;
  logic        cntWe = 1'b0;
  logic [7:0]  intPin = '0;
  logic [15:0] stsOut, enOut, cntOut;
  logic        sciOut, tmrArm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pmSciGen u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrData(wrData),
    .stsClrWe(stsClrWe), .enWe(enWe), .cntWe(cntWe), .intPin(intPin),
    .stsOut(stsOut), .enOut(enOut), .cntOut(cntOut),
    .sciOut(sciOut), .tmrArm(tmrArm)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive is applied right after a negedge; tick passes one posedge
  task automatic tick();
    @(negedge clk);
    evtIn = '0; stsClrWe = 1'b0; enWe = 1'b0; cntWe = 1'b0; wrData = '0;
  endtask

  function automatic bit isSrc(input int b);
    return (b == 0) || (b == 5) || (b == 8) || (b == 10);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    intPin = 8'h01;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sts", stsOut, 16'h0);
    chk("R1 en", enOut, 16'h0);
    chk("R1 cnt", cntOut, 16'h0);
    chk("R1 sci", {15'b0, sciOut}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release sci", {15'b0, sciOut}, 16'h0);
    chk("R1 after release arm", {15'b0, tmrArm}, 16'h0);

    // R5: control and enable load, hold
    wrData = 16'hA5C3; cntWe = 1'b1; tick();
    chk("R5 cnt load", cntOut, 16'hA5C3);
    wrData = 16'h1234; enWe = 1'b1; tick();
    chk("R5 en load", enOut, 16'h1234);
    chk("R5 cnt hold", cntOut, 16'hA5C3);
    tick();
    chk("R5 en hold", enOut, 16'h1234);

    // R2 / R3: set several bits, partial clear
    evtIn = 16'hF00F; tick();
    chk("R2 set", stsOut, 16'hF00F);
    tick();
    chk("R2 hold", stsOut, 16'hF00F);
    wrData = 16'h300C; stsClrWe = 1'b1; tick();
    chk("R3 partial clear", stsOut, 16'hC003);

    // R4: set and clear same bit same cycle
    wrData = 16'hFFFF; stsClrWe = 1'b1; evtIn = 16'h0020; tick();
    chk("R4 set wins", stsOut, 16'h0020);

    // R6 latency: enable power button, pulse it, sci one cycle later
    wrData = 16'hFFFF; stsClrWe = 1'b1; tick();
    wrData = 16'h0100; enWe = 1'b1; tick();
    tick();
    chk("R6 idle low", {15'b0, sciOut}, 16'h0);
    evtIn = 16'h0100; tick();
    chk("R6 not yet high", {15'b0, sciOut}, 16'h0);
    tick();
    chk("R6 high after one cycle", {15'b0, sciOut}, 16'h1);
    // R8: pin to zero drops sci one cycle later
    intPin = 8'h00; tick();
    chk("R8 pin zero drops sci", {15'b0, sciOut}, 16'h0);
    intPin = 8'h80; tick();
    chk("R8 other pin value raises", {15'b0, sciOut}, 16'h1);

    // R6/R7/R8/R9 sweep: bit x status x enable x pin
    for (int b = 0; b < 16; b++) begin
      for (int combo = 0; combo < 8; combo++) begin
        bit s = combo[0];
        bit e = combo[1];
        bit p = combo[2];
        bit expSci, expArm;
        intPin = p ? 8'(b + 1) : 8'h00;
        wrData = 16'hFFFF; stsClrWe = 1'b1; tick();
        wrData = e ? (16'h1 << b) : 16'h0; enWe = 1'b1;
        evtIn  = s ? (16'h1 << b) : 16'h0;
        tick();
        tick();
        expSci = p && s && e && isSrc(b);
        expArm = e && !s && (b == 0);
        chk(isSrc(b) ? (p ? "R6 sweep sci" : "R8 sweep sci") : "R7 sweep sci",
            {15'b0, sciOut}, {15'b0, expSci});
        chk("R9 sweep arm", {15'b0, tmrArm}, {15'b0, expArm});
      end
    end

    // R7: everything except the four sources set and enabled
    intPin = 8'h01;
    wrData = 16'hFFFF; stsClrWe = 1'b1; tick();
    wrData = 16'hFADE; enWe = 1'b1; evtIn = 16'hFADE; tick();
    tick();
    chk("R7 all non-source bits", {15'b0, sciOut}, 16'h0);

    // R9: timer status set disarms, clear rearms
    wrData = 16'h0001; enWe = 1'b1; tick();
    tick();
    chk("R9 armed", {15'b0, tmrArm}, 16'h1);
    evtIn = 16'h0001; tick();
    tick();
    chk("R9 disarmed by status", {15'b0, tmrArm}, 16'h0);
    chk("R6 timer source raises", {15'b0, sciOut}, 16'h1);
    wrData = 16'h0001; stsClrWe = 1'b1; tick();
    tick();
    chk("R9 rearmed", {15'b0, tmrArm}, 16'h1);

    // R1: mid-run reset clears everything
    rstN = 1'b0; @(negedge clk);
    chk("R1 re-reset sts", stsOut, 16'h0);
    chk("R1 re-reset en", enOut, 16'h0);
    chk("R1 re-reset arm", {15'b0, tmrArm}, 16'h0);
    rstN = 1'b1; @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule